// File: doc/BRIEF.md
# I2C Command-Word Sequencer

This block sits between a command queue and a bit-level I2C master engine. The queue holds 10-bit command words. Each word carries one byte in its low eight bits and two flag bits. One flag asks for a START, or a repeated START, before the byte. The other asks for a STOP after it. The sequencer reads the words in order and issues byte-level operations to the engine: start condition, stop condition, byte write and byte read. It waits for the engine's completion strobe after each one. Received bytes leave on a one-cycle strobe.

A word that carries the START flag is always an address byte, with the read/write direction in bit 0. In a read, the word that follows the address is not data. Its low byte gives how many bytes to fetch. The sequencer acknowledges every fetched byte except the last, which it NACKs. If the target refuses a write byte, including the address, the sequencer closes the bus with a STOP. It then drops the queued words up to the next START word. The block reports four event pulses: transmit error, queue empty, queue half empty and bus idle.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A word with bit 8 set makes the sequencer issue a start operation and then write that word's low byte as the address. Bit 0 of the address byte = 0 selects a write. Each following word without bit 8 is written as a data byte. A word with bit 9 set is followed by a stop operation once the engine reports the byte acknowledged.
- R2: A single word with both bit 8 and bit 9 set performs start, address write, stop, and nothing else.
- R3: When the address byte has bit 0 = 1, the next word's low 8 bits give a byte count N. The sequencer issues N read operations. `eng_nack_out` is 0 on the first N-1 reads and 1 on the last. Each byte appears on `rx_byte` with a one-cycle `rx_valid`. Bit 9 in the count word adds a stop operation after the last read.
- R4: A word with bit 8 set that arrives while the bus is still held, after a transfer that had no stop, issues a new start operation with no stop before it.
- R5: A NACK reported by the engine on any write (address or data) raises `ev_tx_error`. The sequencer then issues a stop operation and discards queued words until the head holds a word with bit 8 set. That word then starts the next transfer.
- R6: `ev_tx_error` also pulses once when the final byte of a read completes, the byte the master NACKs.
- R7: `ev_bus_idle` pulses exactly once each time a stop operation completes, in the cycle after the engine's completion strobe.
- R8: The queue holds 16 words. `txf_occ` shows the count minus one, and 0 when `txf_empty` is 1. `txf_full` is 1 at 16 words. A push while the queue is full is dropped.
- R9: `ev_tx_half` pulses when a pop brings the count down to 8. `ev_tx_empty` pulses when a pop brings it down to 0.
- R10: `txf_flush` empties the queue and puts the sequencer in idle, with no engine request, by the next clock. It wins over a push in the same cycle.
- R11: After reset the queue is empty, `txf_occ` = 0, no engine request is raised and all event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_push | input | 1 | Write `cmd_word` into the queue |
| cmd_word | input | 10 | Command word: bit 9 STOP, bit 8 START, bits 7:0 byte |
| txf_flush | input | 1 | Flush the queue and return to idle |
| txf_full | output | 1 | Queue holds 16 words |
| txf_empty | output | 1 | Queue holds no words |
| txf_occ | output | 4 | Word count minus one (0 when empty) |
| eng_req | output | 1 | Operation request to the bit engine, held until `eng_done` |
| eng_op | output | 2 | Operation: 0 start, 1 stop, 2 write byte, 3 read byte |
| eng_wbyte | output | 8 | Byte to write |
| eng_nack_out | output | 1 | Master answers the byte being read with NACK |
| eng_done | input | 1 | One-cycle completion strobe from the engine |
| eng_nack_in | input | 1 | Target did not acknowledge the written byte (valid with `eng_done`) |
| eng_rbyte | input | 8 | Byte received by the engine (valid with `eng_done`) |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| ev_tx_error | output | 1 | Address/data NACK or final read byte NACKed |
| ev_tx_empty | output | 1 | Queue drained to zero |
| ev_tx_half | output | 1 | Queue drained to half |
| ev_bus_idle | output | 1 | Stop condition completed |

## Verification
A flush and a push can land in the same clock. The queue must treat the flush as the winner and drop the incoming word. The bench stalls the engine model so that a transfer is left mid-request and several words sit in the queue. It then raises `txf_flush` and `cmd_push` together for one cycle. It judges the result at the ports: right after that edge the queue must read empty with zero occupancy and no engine request. Once the engine model is released, no engine operation may follow, which shows that the word pushed alongside the flush never entered the queue.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } eng_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HOLD,
      ST_START,
      ST_ADDR,
      ST_WDATA,
      ST_COUNT,
      ST_READ,
      ST_STOP,
      ST_DRAIN
   } seq_state_e;

endpackage

// File: rtl/seq_cmd_fifo.sv
module seq_cmd_fifo #(
   parameter  int DEPTH = 16,
   parameter  int WW    = 10,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [WW-1:0] push_word,
   input  logic          pop,
   output logic [WW-1:0] head_word,
   output logic [AW:0]   count,
   output logic          push_ok,
   output logic          pop_ok
);

   localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

   logic [WW-1:0] store [DEPTH];
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;

   assign push_ok   = push && !flush && (count != CNT_FULL);
   assign pop_ok    = pop && !flush && (count != '0);
   assign head_word = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) begin
         store[wr_ptr] <= push_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) begin
            wr_ptr <= wr_ptr + 1'b1;
         end
         if (pop_ok) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
         if (push_ok && !pop_ok) begin
            count <= count + 1'b1;
         end else if (pop_ok && !push_ok) begin
            count <= count - 1'b1;
         end
      end
   end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import i2cseq_pkg::*;
#(
   parameter  int DW = 8,
   localparam int WW = DW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          fifo_empty,
   input  logic [WW-1:0] head_word,
   output logic          pop,
   output logic          eng_req,
   output eng_op_e       eng_op,
   output logic [DW-1:0] eng_wbyte,
   output logic          eng_nack_out,
   input  logic          eng_done,
   input  logic          eng_nack_in,
   input  logic [DW-1:0] eng_rbyte,
   output logic          rx_valid,
   output logic [DW-1:0] rx_byte,
   output logic          err_pulse,
   output logic          stop_pulse
);

   seq_state_e    state;
   logic [DW-1:0] cur_byte;
   logic          cur_stop;
   logic [DW-1:0] remain;
   logic          drain_q;

   logic          head_start;
   logic          head_stop;
   logic [DW-1:0] head_byte;

   assign head_byte  = head_word[DW-1:0];
   assign head_start = head_word[DW];
   assign head_stop  = head_word[DW+1];

   always_comb begin
      pop = 1'b0;
      unique case (state)
         ST_IDLE, ST_HOLD, ST_COUNT: pop = !fifo_empty;
         ST_DRAIN:                   pop = !fifo_empty && !head_start;
         default:                    pop = 1'b0;
      endcase
   end

   always_comb begin
      eng_req = 1'b0;
      eng_op  = OP_WRITE;
      unique case (state)
         ST_START: begin eng_req = 1'b1; eng_op = OP_START; end
         ST_STOP:  begin eng_req = 1'b1; eng_op = OP_STOP;  end
         ST_READ:  begin eng_req = 1'b1; eng_op = OP_READ;  end
         ST_ADDR, ST_WDATA: begin eng_req = 1'b1; eng_op = OP_WRITE; end
         default:  begin eng_req = 1'b0; eng_op = OP_WRITE; end
      endcase
   end

   assign eng_wbyte    = cur_byte;
   assign eng_nack_out = (state == ST_READ) && (remain == DW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cur_byte   <= '0;
         cur_stop   <= 1'b0;
         remain     <= '0;
         drain_q    <= 1'b0;
         rx_valid   <= 1'b0;
         rx_byte    <= '0;
         err_pulse  <= 1'b0;
         stop_pulse <= 1'b0;
      end else begin
         rx_valid   <= 1'b0;
         err_pulse  <= 1'b0;
         stop_pulse <= 1'b0;
         if (flush) begin
            state   <= ST_IDLE;
            drain_q <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  if (!fifo_empty && head_start) begin
                     cur_byte <= head_byte;
                     cur_stop <= head_stop;
                     state    <= ST_START;
                  end
               end
               ST_HOLD: begin
                  if (!fifo_empty) begin
                     cur_byte <= head_byte;
                     cur_stop <= head_stop;
                     state    <= head_start ? ST_START : ST_WDATA;
                  end
               end
               ST_START: begin
                  if (eng_done) begin
                     state <= ST_ADDR;
                  end
               end
               ST_ADDR: begin
                  if (eng_done) begin
                     if (eng_nack_in) begin
                        err_pulse <= 1'b1;
                        drain_q   <= 1'b1;
                        state     <= ST_STOP;
                     end else if (cur_byte[0]) begin
                        state <= ST_COUNT;
                     end else begin
                        state <= cur_stop ? ST_STOP : ST_HOLD;
                     end
                  end
               end
               ST_WDATA: begin
                  if (eng_done) begin
                     if (eng_nack_in) begin
                        err_pulse <= 1'b1;
                        drain_q   <= 1'b1;
                        state     <= ST_STOP;
                     end else begin
                        state <= cur_stop ? ST_STOP : ST_HOLD;
                     end
                  end
               end
               ST_COUNT: begin
                  if (!fifo_empty) begin
                     remain   <= head_byte;
                     cur_stop <= head_stop;
                     if (head_byte == '0) begin
                        state <= head_stop ? ST_STOP : ST_HOLD;
                     end else begin
                        state <= ST_READ;
                     end
                  end
               end
               ST_READ: begin
                  if (eng_done) begin
                     rx_valid <= 1'b1;
                     rx_byte  <= eng_rbyte;
                     remain   <= remain - 1'b1;
                     if (remain == DW'(1)) begin
                        err_pulse <= 1'b1;
                        state     <= cur_stop ? ST_STOP : ST_HOLD;
                     end
                  end
               end
               ST_STOP: begin
                  if (eng_done) begin
                     stop_pulse <= 1'b1;
                     drain_q    <= 1'b0;
                     state      <= drain_q ? ST_DRAIN : ST_IDLE;
                  end
               end
               ST_DRAIN: begin
                  if (fifo_empty || head_start) begin
                     state <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/seq_events.sv
module seq_events #(
   parameter  int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        push_ok,
   input  logic        pop_ok,
   input  logic [AW:0] count,
   output logic        ev_half,
   output logic        ev_empty
);

   localparam logic [AW:0] CNT_ONE     = (AW+1)'(1);
   localparam logic [AW:0] CNT_HALF_P1 = (AW+1)'(DEPTH / 2 + 1);

   logic drain_step;

   assign drain_step = pop_ok && !push_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_half  <= 1'b0;
         ev_empty <= 1'b0;
      end else begin
         ev_half  <= drain_step && (count == CNT_HALF_P1);
         ev_empty <= drain_step && (count == CNT_ONE);
      end
   end

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
   import i2cseq_pkg::*;
#(
   parameter  int DEPTH = 16,
   parameter  int DW    = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int WW    = DW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_push,
   input  logic [WW-1:0] cmd_word,
   input  logic          txf_flush,
   output logic          txf_full,
   output logic          txf_empty,
   output logic [AW-1:0] txf_occ,
   output logic          eng_req,
   output logic [1:0]    eng_op,
   output logic [DW-1:0] eng_wbyte,
   output logic          eng_nack_out,
   input  logic          eng_done,
   input  logic          eng_nack_in,
   input  logic [DW-1:0] eng_rbyte,
   output logic          rx_valid,
   output logic [DW-1:0] rx_byte,
   output logic          ev_tx_error,
   output logic          ev_tx_empty,
   output logic          ev_tx_half,
   output logic          ev_bus_idle
);

   localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("i2c_cmd_seq: DEPTH must be a power of two of at least 4");
   end
   if (DW < 2) begin : g_bad_width
      $error("i2c_cmd_seq: DW must be at least 2");
   end

   logic [WW-1:0] head_word;
   logic [AW:0]   count;
   logic          push_ok;
   logic          pop_ok;
   logic          seq_pop;
   eng_op_e       op_sel;
   logic          err_pulse;
   logic          stop_pulse;

   seq_cmd_fifo #(.DEPTH(DEPTH), .WW(WW)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (txf_flush),
      .push      (cmd_push),
      .push_word (cmd_word),
      .pop       (seq_pop),
      .head_word (head_word),
      .count     (count),
      .push_ok   (push_ok),
      .pop_ok    (pop_ok)
   );

   seq_ctrl #(.DW(DW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (txf_flush),
      .fifo_empty   (txf_empty),
      .head_word    (head_word),
      .pop          (seq_pop),
      .eng_req      (eng_req),
      .eng_op       (op_sel),
      .eng_wbyte    (eng_wbyte),
      .eng_nack_out (eng_nack_out),
      .eng_done     (eng_done),
      .eng_nack_in  (eng_nack_in),
      .eng_rbyte    (eng_rbyte),
      .rx_valid     (rx_valid),
      .rx_byte      (rx_byte),
      .err_pulse    (err_pulse),
      .stop_pulse   (stop_pulse)
   );

   seq_events #(.DEPTH(DEPTH)) u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .count    (count),
      .ev_half  (ev_tx_half),
      .ev_empty (ev_tx_empty)
   );

   assign eng_op      = op_sel;
   assign txf_empty   = (count == '0);
   assign txf_full    = (count == CNT_FULL);
   assign txf_occ     = txf_empty ? '0 : AW'(count - 1'b1);
   assign ev_tx_error = err_pulse;
   assign ev_bus_idle = stop_pulse;

endmodule

// File: rtl/seq_checker.sv
module seq_checker
   import i2cseq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       txf_flush,
   input logic       txf_full,
   input logic       txf_empty,
   input logic       fifo_pop,
   input logic       eng_req,
   input logic [1:0] eng_op,
   input logic       eng_done,
   input logic       eng_nack_in,
   input logic       rx_valid,
   input logic       ev_bus_idle
);

   // R10: flush leaves an empty queue and no engine request
   p_flush_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      txf_flush |=> (txf_empty && !eng_req));

   // R8: a full queue that is not drained stays full, pushes are dropped
   p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (txf_full && !fifo_pop && !txf_flush) |=> txf_full);

   // R5: a refused write byte is followed by a stop request
   p_stop_after_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_done && eng_nack_in && eng_op == 2'(OP_WRITE) && !txf_flush)
      |=> (eng_req && eng_op == 2'(OP_STOP)));

   // R3: a received byte only follows a completed read operation
   p_rx_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ($past(eng_done) && $past(eng_op) == 2'(OP_READ)));

   // R7: bus idle only follows a completed stop operation
   p_idle_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_bus_idle |-> ($past(eng_done) && $past(eng_op) == 2'(OP_STOP)));

endmodule

bind i2c_cmd_seq seq_checker u_seq_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .txf_flush   (txf_flush),
   .txf_full    (txf_full),
   .txf_empty   (txf_empty),
   .fifo_pop    (pop_ok),
   .eng_req     (eng_req),
   .eng_op      (eng_op),
   .eng_done    (eng_done),
   .eng_nack_in (eng_nack_in),
   .rx_valid    (rx_valid),
   .ev_bus_idle (ev_bus_idle)
);

// File: tb/test_i2c_cmd_seq.sv
`timescale 1ns/1ps
module test_i2c_cmd_seq;
   import i2cseq_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cmd_push;
   logic [9:0] cmd_word;
   logic       txf_flush;
   logic       txf_full, txf_empty;
   logic [3:0] txf_occ;
   logic       eng_req;
   logic [1:0] eng_op;
   logic [7:0] eng_wbyte;
   logic       eng_nack_out;
   logic       eng_done;
   logic       eng_nack_in;
   logic [7:0] eng_rbyte;
   logic       rx_valid;
   logic [7:0] rx_byte;
   logic       ev_tx_error, ev_tx_empty, ev_tx_half, ev_bus_idle;

   always #4 clk = ~clk;

   i2c_cmd_seq i_i2c_cmd_seq (
      .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_word(cmd_word),
      .txf_flush(txf_flush), .txf_full(txf_full), .txf_empty(txf_empty),
      .txf_occ(txf_occ), .eng_req(eng_req), .eng_op(eng_op),
      .eng_wbyte(eng_wbyte), .eng_nack_out(eng_nack_out), .eng_done(eng_done),
      .eng_nack_in(eng_nack_in), .eng_rbyte(eng_rbyte), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .ev_tx_error(ev_tx_error), .ev_tx_empty(ev_tx_empty),
      .ev_tx_half(ev_tx_half), .ev_bus_idle(ev_bus_idle)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // engine model state and logs
   logic       hold;
   int         nack_at;
   logic       busy, cool;
   int         lat;
   logic [1:0] lop;
   logic [7:0] lbyte;
   logic       lackn;
   int         wr_cnt, rd_cnt, log_n;
   logic [1:0] log_op   [128];
   logic [7:0] log_byte [128];
   logic       log_ackn [128];

   int         n_err, n_empty, n_half, n_idle, rx_n;
   logic [7:0] rx_log [128];

   always @(posedge clk) begin
      if (!rst_n) begin
         eng_done <= 1'b0; eng_nack_in <= 1'b0; eng_rbyte <= 8'h00;
         busy <= 1'b0; cool <= 1'b0; lat <= 0;
         lop <= 2'd0; lbyte <= 8'h00; lackn <= 1'b0;
         wr_cnt = 0; rd_cnt = 0; log_n = 0;
      end else if (eng_done) begin
         eng_done <= 1'b0; eng_nack_in <= 1'b0; cool <= 1'b1;
      end else if (cool) begin
         cool <= 1'b0;
      end else if (busy) begin
         if (lat == 0) begin
            eng_done <= 1'b1;
            busy     <= 1'b0;
            if (log_n < 128) begin
               log_op[log_n] = lop; log_byte[log_n] = lbyte; log_ackn[log_n] = lackn;
            end
            log_n = log_n + 1;
            if (lop == 2'(OP_WRITE)) begin
               if (wr_cnt == nack_at) eng_nack_in <= 1'b1;
               wr_cnt = wr_cnt + 1;
            end
            if (lop == 2'(OP_READ)) begin
               eng_rbyte <= 8'hC0 + 8'(rd_cnt);
               rd_cnt = rd_cnt + 1;
            end
         end else begin
            lat <= lat - 1;
         end
      end else if (eng_req && !hold) begin
         busy <= 1'b1; lat <= 2;
         lop <= eng_op; lbyte <= eng_wbyte; lackn <= eng_nack_out;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         n_err = 0; n_empty = 0; n_half = 0; n_idle = 0; rx_n = 0;
      end else begin
         if (ev_tx_error) n_err = n_err + 1;
         if (ev_tx_empty) n_empty = n_empty + 1;
         if (ev_tx_half)  n_half = n_half + 1;
         if (ev_bus_idle) n_idle = n_idle + 1;
         if (rx_valid) begin
            if (rx_n < 128) rx_log[rx_n] = rx_byte;
            rx_n = rx_n + 1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [9:0] cw(input bit s, input bit p, input logic [7:0] b);
      return {p, s, b};
   endfunction

   task automatic push(input logic [9:0] w);
      @(negedge clk);
      cmd_push = 1'b1;
      cmd_word = w;
      @(negedge clk);
      cmd_push = 1'b0;
   endtask

   task automatic wait_idle(input int target, input string tag);
      int g = 0;
      while (n_idle < target && g < 3000) begin
         @(negedge clk);
         g++;
      end
      repeat (6) @(negedge clk);
      check(n_idle == target, tag, n_idle, target);
   endtask

   task automatic expect_op(input int idx, input logic [1:0] op, input logic [7:0] b,
                            input logic ackn, input string tag);
      check(log_op[idx] == op, {tag, " op"}, log_op[idx], op);
      if (op == 2'(OP_WRITE)) check(log_byte[idx] == b, {tag, " byte"}, log_byte[idx], b);
      if (op == 2'(OP_READ))  check(log_ackn[idx] == ackn, {tag, " ack"}, log_ackn[idx], ackn);
   endtask

   task automatic t_reset;
      check(txf_empty == 1'b1, "R11 empty", txf_empty, 1);
      check(txf_occ == 4'd0, "R11 occ", txf_occ, 0);
      check(eng_req == 1'b0, "R11 req", eng_req, 0);
      check({ev_tx_error, ev_tx_empty, ev_tx_half, ev_bus_idle} == 4'b0, "R11 events",
            {ev_tx_error, ev_tx_empty, ev_tx_half, ev_bus_idle}, 0);
   endtask

   task automatic t_write;
      int b = log_n; int ib = n_idle; int eb = n_err;
      hold = 1'b1;
      push(cw(1, 0, 8'hA0)); push(cw(0, 0, 8'hAA)); push(cw(0, 1, 8'h55));
      hold = 1'b0;
      wait_idle(ib + 1, "R7 write idle count");
      check(log_n - b == 5, "R1 op count", log_n - b, 5);
      expect_op(b,     2'(OP_START), 8'h00, 1'b0, "R1 start");
      expect_op(b + 1, 2'(OP_WRITE), 8'hA0, 1'b0, "R1 addr");
      expect_op(b + 2, 2'(OP_WRITE), 8'hAA, 1'b0, "R1 data0");
      expect_op(b + 3, 2'(OP_WRITE), 8'h55, 1'b0, "R1 data1");
      expect_op(b + 4, 2'(OP_STOP),  8'h00, 1'b0, "R1 stop");
      check(n_err == eb, "R1 no error", n_err, eb);
   endtask

   task automatic t_addr_only;
      int b = log_n; int ib = n_idle;
      hold = 1'b1;
      push(cw(1, 1, 8'hB0));
      hold = 1'b0;
      wait_idle(ib + 1, "R2 idle");
      check(log_n - b == 3, "R2 op count", log_n - b, 3);
      expect_op(b,     2'(OP_START), 8'h00, 1'b0, "R2 start");
      expect_op(b + 1, 2'(OP_WRITE), 8'hB0, 1'b0, "R2 addr");
      expect_op(b + 2, 2'(OP_STOP),  8'h00, 1'b0, "R2 stop");
   endtask

   task automatic t_read;
      int b = log_n; int ib = n_idle; int eb = n_err; int rb = rx_n; int db = rd_cnt;
      hold = 1'b1;
      push(cw(1, 0, 8'hA1)); push(cw(0, 1, 8'd3));
      hold = 1'b0;
      wait_idle(ib + 1, "R3 idle");
      check(log_n - b == 6, "R3 op count", log_n - b, 6);
      expect_op(b,     2'(OP_START), 8'h00, 1'b0, "R3 start");
      expect_op(b + 1, 2'(OP_WRITE), 8'hA1, 1'b0, "R3 addr");
      expect_op(b + 2, 2'(OP_READ),  8'h00, 1'b0, "R3 read0 ack");
      expect_op(b + 3, 2'(OP_READ),  8'h00, 1'b0, "R3 read1 ack");
      expect_op(b + 4, 2'(OP_READ),  8'h00, 1'b1, "R3 read2 nack");
      expect_op(b + 5, 2'(OP_STOP),  8'h00, 1'b0, "R3 stop");
      check(rx_n - rb == 3, "R3 rx count", rx_n - rb, 3);
      for (int k = 0; k < 3; k++) begin
         check(rx_log[rb + k] == 8'hC0 + 8'(db + k), "R3 rx byte", rx_log[rb + k], 8'hC0 + 8'(db + k));
      end
      check(n_err == eb + 1, "R6 final nack error", n_err, eb + 1);
   endtask

   task automatic t_restart;
      int b = log_n; int ib = n_idle;
      hold = 1'b1;
      push(cw(1, 0, 8'hA0)); push(cw(0, 0, 8'h01));
      push(cw(1, 0, 8'hA1)); push(cw(0, 1, 8'd1));
      hold = 1'b0;
      wait_idle(ib + 1, "R4 idle");
      check(log_n - b == 7, "R4 op count", log_n - b, 7);
      expect_op(b + 2, 2'(OP_WRITE), 8'h01, 1'b0, "R4 data");
      expect_op(b + 3, 2'(OP_START), 8'h00, 1'b0, "R4 restart");
      expect_op(b + 4, 2'(OP_WRITE), 8'hA1, 1'b0, "R4 addr");
      expect_op(b + 5, 2'(OP_READ),  8'h00, 1'b1, "R4 single read nack");
      expect_op(b + 6, 2'(OP_STOP),  8'h00, 1'b0, "R4 stop");
   endtask

   task automatic t_nack;
      int b = log_n; int ib = n_idle; int eb = n_err;
      hold = 1'b1;
      nack_at = wr_cnt;
      push(cw(1, 0, 8'hA0)); push(cw(0, 0, 8'h11)); push(cw(0, 0, 8'h22));
      push(cw(1, 0, 8'hA2)); push(cw(0, 1, 8'h33));
      hold = 1'b0;
      wait_idle(ib + 2, "R5 idle count");
      check(n_err == eb + 1, "R5 error", n_err, eb + 1);
      check(log_n - b == 7, "R5 op count", log_n - b, 7);
      expect_op(b + 1, 2'(OP_WRITE), 8'hA0, 1'b0, "R5 refused addr");
      expect_op(b + 2, 2'(OP_STOP),  8'h00, 1'b0, "R5 stop");
      expect_op(b + 3, 2'(OP_START), 8'h00, 1'b0, "R5 next start");
      expect_op(b + 4, 2'(OP_WRITE), 8'hA2, 1'b0, "R5 next addr");
      expect_op(b + 5, 2'(OP_WRITE), 8'h33, 1'b0, "R5 next data");
      nack_at = -1;
   endtask

   task automatic t_fill;
      int b = log_n; int ib = n_idle; int hb; int mb;
      hold = 1'b1;
      push(cw(1, 0, 8'hA0));
      for (int k = 1; k < 16; k++) push(cw(0, 0, 8'(k)));
      push(cw(0, 1, 8'hEF));
      @(negedge clk);
      check(txf_full == 1'b1, "R8 full", txf_full, 1);
      check(txf_occ == 4'd15, "R8 occ", txf_occ, 15);
      push(cw(0, 0, 8'h77));
      @(negedge clk);
      check(txf_occ == 4'd15, "R8 dropped push", txf_occ, 15);
      hb = n_half; mb = n_empty;
      hold = 1'b0;
      wait_idle(ib + 1, "R9 idle");
      check(n_half == hb + 1, "R9 half event", n_half, hb + 1);
      check(n_empty == mb + 1, "R9 empty event", n_empty, mb + 1);
      check(log_n - b == 19, "R8 op count", log_n - b, 19);
      expect_op(b + 17, 2'(OP_WRITE), 8'hEF, 1'b0, "R8 last byte");
      expect_op(b + 18, 2'(OP_STOP),  8'h00, 1'b0, "R8 stop");
   endtask

   task automatic t_flush;
      int b;
      hold = 1'b1;
      push(cw(1, 0, 8'hA4)); push(cw(0, 0, 8'h01)); push(cw(0, 0, 8'h02)); push(cw(0, 1, 8'h03));
      b = log_n;
      @(negedge clk);
      cmd_push = 1'b1; cmd_word = cw(1, 1, 8'hC8); txf_flush = 1'b1;
      @(negedge clk);
      cmd_push = 1'b0; txf_flush = 1'b0;
      check(txf_empty == 1'b1, "R10 empty", txf_empty, 1);
      check(txf_occ == 4'd0, "R10 occ", txf_occ, 0);
      check(eng_req == 1'b0, "R10 no request", eng_req, 0);
      hold = 1'b0;
      repeat (40) @(negedge clk);
      check(log_n == b, "R10 no ops after flush", log_n - b, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cmd_push = 1'b0; cmd_word = '0; txf_flush = 1'b0;
      hold = 1'b0; nack_at = -1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_addr_only();
      t_read();
      t_restart();
      t_nack();
      t_fill();
      t_flush();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule